// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures the frequency of an unknown clock by counting its rising edges over a window made of a programmable number of reference clock cycles. Control, result and status all live in the reference domain. The counter itself runs on the measured clock. The window's opening and closing edges cross into the measured domain as toggles. The closing edge is echoed back, and the reference side captures the held count only after that echo arrives.

Once the count is captured, a sequential divider converts it to kilohertz as `count * REF_KHZ / window`. The count and the frequency are then frozen until a clear command. Software can take two samples of the result with the sample strobe. The block reports the reading as stable only if both samples were taken while the result was final and both returned the same count. Otherwise the reading is treated as busy or unstable.

Top module: `ref_gated_freq_counter`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `stable_o`, `count_o` and `freq_o` are all 0.
- R2: A `start_i` pulse in the idle state with `window_i` = N (N ≥ 1) opens a window of N reference cycles. When the window has closed, `done_o` rises and `count_o` holds the number of measured-clock rising edges in the window. That number lies within ±1 of floor(N · T_ref / T_meas).
- R3: `window_i` = 0 selects the default window of `DEF_WIN` reference cycles (100 by default).
- R4: The edge counter saturates at 2^COUNT_W − 1 and never wraps.
- R5: While `done_o` is 1 and no clear is given, `count_o` and `freq_o` stay unchanged. `start_i` has no effect while a measurement is running or a result is held.
- R6: `clr_i` in the done or idle state returns the block to idle with `count_o`, `freq_o`, `done_o` and the sample history cleared. `clr_i` has no effect while `busy_o` is 1.
- R7: Whenever `done_o` is 1, `freq_o` equals floor(`count_o` · REF_KHZ / N), where N is the effective window.
- R8: On each `sample_i` cycle the current count is recorded. In the next cycle, `stable_o` is 1 only if this sample and the previous sample since the last clear were both taken with `done_o` = 1 and returned equal counts. Otherwise it is 0.
- R9: `busy_o` is 1 from the cycle after `start_i` is accepted until `done_o` rises. It never falls without `done_o` rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock; control and results domain |
| meas_clk_i | input | 1 | Clock under measurement |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| clr_i | input | 1 | Clear held result and sample history |
| start_i | input | 1 | Start a measurement (accepted only when idle) |
| window_i | input | WIN_W | Window length in reference cycles; 0 selects DEF_WIN |
| sample_i | input | 1 | Sample strobe for the stability check |
| busy_o | output | 1 | Measurement or conversion in progress |
| done_o | output | 1 | Result held and valid |
| count_o | output | COUNT_W | Held edge count |
| freq_o | output | COUNT_W+clog2(REF_KHZ+1) | Measured frequency in kHz |
| stable_o | output | 1 | Last two samples were final and equal |

## Verification
A toggle lost or doubled in either crossing shows up as a measurement that never completes: `busy_o` stays high past a window plus a few cycles of both clocks. A skewed window or a miscounted edge moves `count_o` off the period ratio by more than one, and that is visible as soon as `done_o` rises. Errors in the divider show up in `freq_o` in the same cycle that `done_o` rises. Errors in the hold or sample-history state show up one cycle after a clear or a sample strobe.

// File: rtl/fcnt_pkg.sv
`timescale 1ns/1ps
package fcnt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_WAIT = 3'd2,
    ST_DIV  = 3'd3,
    ST_DONE = 3'd4
  } fcnt_state_e;
endpackage

// File: rtl/fcnt_sync.sv
`timescale 1ns/1ps
module fcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fcnt_meas_core.sv
`timescale 1ns/1ps
module fcnt_meas_core #(
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_tgl_i,
  input  logic               close_tgl_i,
  output logic               ack_tgl_o,
  output logic [COUNT_W-1:0] cnt_o
);
  localparam logic [COUNT_W-1:0] CntMax = '1;

  logic open_s, close_s, open_d, close_d;
  logic run_q, ack_q;
  logic [COUNT_W-1:0] cnt_q;

  fcnt_sync #(.STAGES(SYNC_STAGES)) i_sync_open (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(open_tgl_i), .q_o(open_s));
  fcnt_sync #(.STAGES(SYNC_STAGES)) i_sync_close (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(close_tgl_i), .q_o(close_s));

  wire open_edge  = open_s ^ open_d;
  wire close_edge = close_s ^ close_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_d  <= 1'b0;
      close_d <= 1'b0;
      run_q   <= 1'b0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      open_d  <= open_s;
      close_d <= close_s;
      if (open_edge) begin
        // both edges in one cycle: window shorter than a measured period
        cnt_q <= '0;
        run_q <= ~close_edge;
        if (close_edge) ack_q <= ~ack_q;
      end else if (close_edge) begin
        run_q <= 1'b0;
        ack_q <= ~ack_q;
        if (run_q && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
      end else if (run_q && cnt_q != CntMax) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ack_tgl_o = ack_q;
  assign cnt_o     = cnt_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == CntMax && !open_edge) |=> (cnt_q == CntMax));
endmodule

// File: rtl/fcnt_div.sv
`timescale 1ns/1ps
module fcnt_div #(
  parameter int NUM_W = 33,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int PROD_W = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0]  quo_q, num_q;
  logic [DEN_W-1:0]  rem_q, den_q;
  logic [STEP_W-1:0] step_q;
  logic              act_q, done_q;
  logic [DEN_W:0]    rem_sh, rem_nx;
  logic              fits;

  always_comb begin
    rem_sh = {rem_q, quo_q[NUM_W-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        quo_q  <= num_i;
        num_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        step_q <= STEP_W'(NUM_W);
        act_q  <= 1'b1;
      end else if (act_q) begin
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        rem_q  <= rem_nx[DEN_W-1:0];
        step_q <= step_q - 1'b1;
        if (step_q == STEP_W'(1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  p_quotient_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (PROD_W'(quo_q) * PROD_W'(den_q) + PROD_W'(rem_q) == PROD_W'(num_q))
               && (rem_q < den_q));
endmodule

// File: rtl/fcnt_ref_ctrl.sv
`timescale 1ns/1ps
module fcnt_ref_ctrl
  import fcnt_pkg::*;
#(
  parameter int COUNT_W     = 16,
  parameter int WIN_W       = 16,
  parameter int FREQ_W      = 33,
  parameter int REF_KHZ     = 125000,
  parameter int DEF_WIN     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic [WIN_W-1:0]   window_i,
  input  logic               sample_i,
  output logic               open_tgl_o,
  output logic               close_tgl_o,
  input  logic               ack_tgl_i,
  input  logic [COUNT_W-1:0] meas_cnt_i,
  output logic               div_go_o,
  output logic [FREQ_W-1:0]  div_num_o,
  output logic [WIN_W-1:0]   div_den_o,
  input  logic               div_done_i,
  input  logic [FREQ_W-1:0]  div_quo_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [COUNT_W-1:0] count_o,
  output logic [FREQ_W-1:0]  freq_o,
  output logic               stable_o
);
  fcnt_state_e       state_q;
  logic              open_q, close_q, ack_s, go_q;
  logic [WIN_W-1:0]  win_q, left_q;
  logic [COUNT_W-1:0] count_q, snap_q;
  logic [FREQ_W-1:0] freq_q;
  logic              snap_ok_q, stable_q;

  wire [WIN_W-1:0] eff_win = (window_i == '0) ? WIN_W'(DEF_WIN) : window_i;

  fcnt_sync #(.STAGES(SYNC_STAGES)) i_sync_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      open_q  <= 1'b0;
      close_q <= 1'b0;
      go_q    <= 1'b0;
      win_q   <= '0;
      left_q  <= '0;
      count_q <= '0;
      freq_q  <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          open_q  <= ~open_q;
          win_q   <= eff_win;
          left_q  <= eff_win;
          count_q <= '0;
          freq_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (left_q == WIN_W'(1)) begin
            close_q <= ~close_q;
            state_q <= ST_WAIT;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        ST_WAIT: if (ack_s == close_q) begin
          // count is frozen in the measured domain once the ack toggles
          count_q <= meas_cnt_i;
          go_q    <= 1'b1;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done_i) begin
          freq_q  <= div_quo_i;
          state_q <= ST_DONE;
        end
        ST_DONE: if (clr_i) begin
          count_q <= '0;
          freq_q  <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      snap_ok_q <= 1'b0;
      stable_q  <= 1'b0;
    end else if (clr_i && !busy_o) begin
      snap_ok_q <= 1'b0;
      stable_q  <= 1'b0;
    end else if (sample_i) begin
      stable_q  <= snap_ok_q && done_o && (count_q == snap_q);
      snap_q    <= count_q;
      snap_ok_q <= done_o;
    end
  end

  assign busy_o      = (state_q == ST_RUN) || (state_q == ST_WAIT) || (state_q == ST_DIV);
  assign done_o      = (state_q == ST_DONE);
  assign open_tgl_o  = open_q;
  assign close_tgl_o = close_q;
  assign div_go_o    = go_q;
  assign div_num_o   = FREQ_W'(count_q) * FREQ_W'(REF_KHZ);
  assign div_den_o   = win_q;
  assign count_o     = count_q;
  assign freq_o      = freq_q;
  assign stable_o    = stable_q;

  p_result_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (done_o && $stable(count_o) && $stable(freq_o)));

  p_clear_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && clr_i) |=> (!done_o && count_o == '0 && freq_o == '0 && !stable_o));

  p_busy_to_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  p_stable_needs_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !done_o && !(clr_i && !busy_o)) |=> !stable_o);
endmodule

// File: rtl/ref_gated_freq_counter.sv
`timescale 1ns/1ps
module ref_gated_freq_counter #(
  parameter int COUNT_W     = 16,
  parameter int WIN_W       = 16,
  parameter int REF_KHZ     = 125000,
  parameter int DEF_WIN     = 100,
  parameter int SYNC_STAGES = 2,
  localparam int REF_W      = $clog2(REF_KHZ + 1),
  localparam int FREQ_W     = COUNT_W + REF_W
) (
  input  logic               ref_clk_i,
  input  logic               meas_clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic [WIN_W-1:0]   window_i,
  input  logic               sample_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [COUNT_W-1:0] count_o,
  output logic [FREQ_W-1:0]  freq_o,
  output logic               stable_o
);
  logic               open_tgl, close_tgl, ack_tgl;
  logic [COUNT_W-1:0] meas_cnt;
  logic               div_go, div_done;
  logic [FREQ_W-1:0]  div_num, div_quo;
  logic [WIN_W-1:0]   div_den;

  fcnt_ref_ctrl #(
    .COUNT_W(COUNT_W), .WIN_W(WIN_W), .FREQ_W(FREQ_W),
    .REF_KHZ(REF_KHZ), .DEF_WIN(DEF_WIN), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .clr_i(clr_i), .start_i(start_i), .window_i(window_i), .sample_i(sample_i),
    .open_tgl_o(open_tgl), .close_tgl_o(close_tgl), .ack_tgl_i(ack_tgl),
    .meas_cnt_i(meas_cnt),
    .div_go_o(div_go), .div_num_o(div_num), .div_den_o(div_den),
    .div_done_i(div_done), .div_quo_i(div_quo),
    .busy_o(busy_o), .done_o(done_o), .count_o(count_o),
    .freq_o(freq_o), .stable_o(stable_o)
  );

  fcnt_meas_core #(.COUNT_W(COUNT_W), .SYNC_STAGES(SYNC_STAGES)) i_meas (
    .clk_i(meas_clk_i), .rst_ni(rst_ni),
    .open_tgl_i(open_tgl), .close_tgl_i(close_tgl),
    .ack_tgl_o(ack_tgl), .cnt_o(meas_cnt)
  );

  fcnt_div #(.NUM_W(FREQ_W), .DEN_W(WIN_W)) i_div (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .go_i(div_go), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quo_o(div_quo)
  );
endmodule

// File: tb/test_ref_gated_freq_counter.sv
`timescale 1ns/1ps
module test_ref_gated_freq_counter;
  localparam int COUNT_W = 12;
  localparam int WIN_W   = 16;
  localparam int REF_KHZ = 125000;
  localparam int FREQ_W  = COUNT_W + $clog2(REF_KHZ + 1);
  localparam int REF_PS  = 8000;
  localparam int NVEC    = 6;
  // {measured half period in ps, window}
  localparam int VEC [NVEC][2] = '{
    '{3100, 100}, '{10000, 50}, '{2000, 37},
    '{1700, 200}, '{25000, 9},  '{4000, 1}
  };

  logic ref_clk = 1'b0, meas_clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, start = 1'b0, sample = 1'b0;
  logic [WIN_W-1:0] window = '0;
  logic busy, done, stable;
  logic [COUNT_W-1:0] count;
  logic [FREQ_W-1:0]  freq;
  int   meas_half_ps = 3100;
  int   checks = 0, errors = 0, cycles = 0;

  always #4 ref_clk = ~ref_clk;
  initial forever #(real'(meas_half_ps) / 1000.0) meas_clk = ~meas_clk;

  ref_gated_freq_counter #(.COUNT_W(COUNT_W), .WIN_W(WIN_W), .REF_KHZ(REF_KHZ),
                           .DEF_WIN(100)) i_ref_gated_freq_counter (
    .ref_clk_i(ref_clk), .meas_clk_i(meas_clk), .rst_ni(rst_n),
    .clr_i(clr), .start_i(start), .window_i(window), .sample_i(sample),
    .busy_o(busy), .done_o(done), .count_o(count), .freq_o(freq), .stable_o(stable));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_start(input int win);
    window = WIN_W'(win); start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) tick();
  endtask

  task automatic check_result(input int half, input int win, input string req);
    longint ideal, f_exp;
    ideal = longint'(win) * REF_PS / (2 * half);
    if (ideal > (1 << COUNT_W) - 1) ideal = (1 << COUNT_W) - 1;
    chk(done == 1'b1, {req, " done"}, done, 1);
    chk((count + 1 >= ideal) && (count <= ideal + 1), {req, " count"}, count, ideal);
    f_exp = longint'(count) * REF_KHZ / win;
    chk(freq == FREQ_W'(f_exp), "R7 freq", freq, f_exp);
  endtask

  task automatic do_clear();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic double_sample();
    sample = 1'b1; tick(2); sample = 1'b0;
  endtask

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1
    chk(!busy && !done && !stable, "R1 flags", {busy, done, stable}, 0);
    chk(count == 0 && freq == 0, "R1 result", count, 0);

    for (int v = 0; v < NVEC; v++) begin
      meas_half_ps = VEC[v][0];
      tick(4);
      pulse_start(VEC[v][1]);
      chk(busy == 1'b1, "R9 busy", busy, 1);
      wait_done();
      check_result(VEC[v][0], VEC[v][1], "R2");
      do_clear();
    end

    // R3 default window
    meas_half_ps = 3100;
    tick(4);
    pulse_start(0);
    wait_done();
    check_result(3100, 100, "R3");

    // R8 two final equal samples
    double_sample();
    chk(stable == 1'b1, "R8 stable after two final samples", stable, 1);

    // R5 start ignored while done
    begin
      logic [COUNT_W-1:0] held_c;
      logic [FREQ_W-1:0]  held_f;
      held_c = count; held_f = freq;
      pulse_start(7);
      tick(200);
      chk(done && !busy, "R5 still done", {done, busy}, 2);
      chk(count == held_c && freq == held_f, "R5 count held", count, held_c);
    end

    // R6 clear
    do_clear();
    chk(!done && count == 0 && freq == 0 && !stable, "R6 cleared", count, 0);
    double_sample();
    chk(stable == 1'b0, "R8 idle samples not stable", stable, 0);

    // R8 sample during busy then after done
    pulse_start(150);
    sample = 1'b1; tick(); sample = 1'b0;
    wait_done();
    sample = 1'b1; tick(); sample = 1'b0;
    chk(stable == 1'b0, "R8 busy sample not stable", stable, 0);
    do_clear();

    // R6 clear ignored while busy; R5 start ignored while busy
    pulse_start(300);
    tick(50);
    do_clear();
    pulse_start(5);
    chk(busy == 1'b1, "R6 clear ignored busy", busy, 1);
    wait_done();
    check_result(3100, 300, "R6");
    do_clear();

    // R4 saturation
    meas_half_ps = 1500;
    tick(4);
    pulse_start(2000);
    wait_done();
    chk(count == COUNT_W'((1 << COUNT_W) - 1), "R4 saturate", count, (1 << COUNT_W) - 1);
    check_result(1500, 2000, "R4");
    do_clear();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule